// File: doc/BRIEF.md
# Cell-Granular Buffer with Framing Checks

This block sits between a word-stream producer that marks packet starts and a consumer that moves whole fixed-length cells. The producer writes one word per cycle with a valid strobe, a start-of-packet marker and an error marker. The buffer tracks each cell by word count. It checks that the start marker sits on the first word and nowhere else. A cell becomes readable only after its last word has been stored. When the producer begins a cell and no whole slot is free, the buffer drops the entire cell.

The reader pulls one word per strobe. Each word comes back with regenerated start and end markers and with the cell's accumulated error flag. Storage is organised as a fixed number of cell slots. Occupancy is counted in whole cells, and the space indication looks ahead by one complete cell. A cell that breaks the start-marker rule is either dropped or kept with its error flag set, chosen by a parameter.

Top module: `cell_fifo`

## Requirements
- R1: The buffer holds NUM_CELLS (default 4) complete cells of CELL_WORDS (default 13) words each, and returns them in write order with all data intact.
- R2: cell_space_o is high exactly when the committed cells plus any cell currently being written number fewer than NUM_CELLS. It is high after reset.
- R3: A valid write of a cell's first word while cell_space_o is low pulses ovf_err_o one cycle later, and all CELL_WORDS words of that cell are discarded and never become readable.
- R4: An rd_strobe_i while cell_avail_o is low pulses udf_err_o one cycle later, and rd_valid_o stays low.
- R5: Every valid write that carries wr_sop_i=1 pulses sop_pulse_o one cycle later.
- R6: sop_err_o pulses one cycle after a valid first word without wr_sop_i, and one cycle after a valid non-first word with wr_sop_i.
- R7: With DROP_BAD_SOP=1 (default), a cell that has any start-marker error is discarded. With DROP_BAD_SOP=0, it is committed with its error flag set.
- R8: One cycle after an accepted rd_strobe_i, rd_valid_o is high with the stored word. rd_sop_o is high on word 0 of the cell, and rd_eop_o is high on word CELL_WORDS-1 only.
- R9: rd_err_o is high on every word of a cell when wr_err_i was high on any of its words, and low on every word of a clean cell.
- R10: cell_avail_o stays low while a cell is only partly written. It is high from the cycle after a cell's last word is written, for as long as one or more complete cells are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write word valid |
| wr_data_i | input | DATA_W | Write word |
| wr_sop_i | input | 1 | Start-of-packet marker on the write word |
| wr_err_i | input | 1 | Error marker on the write word |
| cell_space_o | output | 1 | A complete cell can be accepted |
| sop_pulse_o | output | 1 | Start marker seen on a valid write |
| sop_err_o | output | 1 | Start marker missing or misplaced |
| ovf_err_o | output | 1 | Cell dropped for lack of space |
| rd_strobe_i | input | 1 | Read one word |
| cell_avail_o | output | 1 | A complete cell is stored |
| rd_valid_o | output | 1 | Read word valid |
| rd_data_o | output | DATA_W | Read word |
| rd_sop_o | output | 1 | First word of a cell |
| rd_eop_o | output | 1 | Last word of a cell |
| rd_err_o | output | 1 | Cell carries an error |
| udf_err_o | output | 1 | Read attempted with no complete cell |

## Verification
All write-side pulses (sop_pulse_o, sop_err_o, ovf_err_o) and all read results (rd_valid_o, data, markers, udf_err_o) appear exactly one cycle after the edge that samples the stimulus. The occupancy flags cell_avail_o and cell_space_o change on that same edge. The bench drives every input on the falling edge and samples on the next falling edge, so each result is read in the cycle it is due. Pulse counts are added up over each cell, which makes a pulse that is missing, duplicated or one word late show up as a wrong total.

// File: rtl/cf_pkg.sv
package cf_pkg;
  typedef struct packed {
    logic sop;
    logic eop;
    logic err;
  } cf_mark_t;
endpackage

// File: rtl/cf_occ.sv
module cf_occ #(
  parameter int NUM_CELLS = 4,
  localparam int CNT_W = $clog2(NUM_CELLS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic commit_i,
  input  logic release_i,
  input  logic busy_i,
  output logic avail_o,
  output logic space_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (commit_i && !release_i) cnt_q <= cnt_q + CNT_W'(1);
    else if (!commit_i && release_i) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign avail_o = cnt_q != '0;
  // in-progress cell reserves its slot
  assign space_o = ((CNT_W+1)'(cnt_q) + (CNT_W+1)'(busy_i)) < (CNT_W+1)'(NUM_CELLS);

  // R1
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NUM_CELLS));

  // R2
  no_commit_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !release_i) |-> (cnt_q < CNT_W'(NUM_CELLS)));
endmodule

// File: rtl/cf_store.sv
module cf_store #(
  parameter int DATA_W     = 32,
  parameter int CELL_WORDS = 13,
  parameter int NUM_CELLS  = 4,
  localparam int WORD_W = $clog2(CELL_WORDS),
  localparam int SLOT_W = $clog2(NUM_CELLS),
  localparam int DEPTH  = NUM_CELLS * CELL_WORDS,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] wslot_i,
  input  logic [WORD_W-1:0] wword_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fwe_i,
  input  logic              fval_i,
  input  logic              re_i,
  input  logic [SLOT_W-1:0] rslot_i,
  input  logic [WORD_W-1:0] rword_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rflag_o
);
  logic [DATA_W-1:0]    mem [DEPTH];
  logic [NUM_CELLS-1:0] flag_q;
  logic [ADDR_W-1:0]    waddr, raddr;

  assign waddr = ADDR_W'(wslot_i) * ADDR_W'(CELL_WORDS) + ADDR_W'(wword_i);
  assign raddr = ADDR_W'(rslot_i) * ADDR_W'(CELL_WORDS) + ADDR_W'(rword_i);

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr];
  end

  for (genvar s = 0; s < NUM_CELLS; s++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[s] <= 1'b0;
      else if (fwe_i && wslot_i == SLOT_W'(s)) flag_q[s] <= fval_i;
    end
  end

  assign rflag_o = flag_q[rslot_i];
endmodule

// File: rtl/cf_wr_ctrl.sv
module cf_wr_ctrl #(
  parameter int DATA_W       = 32,
  parameter int CELL_WORDS   = 13,
  parameter int NUM_CELLS    = 4,
  parameter bit DROP_BAD_SOP = 1'b1,
  localparam int WORD_W = $clog2(CELL_WORDS),
  localparam int SLOT_W = $clog2(NUM_CELLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sop_i,
  input  logic              err_i,
  input  logic              space_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [WORD_W-1:0] word_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              commit_o,
  output logic              commit_err_o,
  output logic              sop_pulse_o,
  output logic              sop_err_o,
  output logic              ovf_o
);
  logic [WORD_W-1:0] word_q;
  logic [SLOT_W-1:0] slot_q;
  logic discard_q, sop_bad_q, err_q;
  logic first, last, drop_now, bad_word, bad_acc, err_acc, keep;

  always_comb begin
    first    = word_q == '0;
    last     = word_q == WORD_W'(CELL_WORDS - 1);
    drop_now = first ? !space_i : discard_q;
    bad_word = first ? !sop_i : sop_i;
    bad_acc  = (!first && sop_bad_q) || bad_word;
    err_acc  = (!first && err_q) || err_i;
    keep     = !drop_now && !(DROP_BAD_SOP && bad_acc);
  end

  assign busy_o       = !first && !discard_q;
  assign mem_we_o     = valid_i && !drop_now;
  assign slot_o       = slot_q;
  assign word_o       = word_q;
  assign mem_data_o   = data_i;
  assign commit_o     = valid_i && last && keep;
  assign commit_err_o = err_acc || bad_acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q      <= '0;
      slot_q      <= '0;
      discard_q   <= 1'b0;
      sop_bad_q   <= 1'b0;
      err_q       <= 1'b0;
      sop_pulse_o <= 1'b0;
      sop_err_o   <= 1'b0;
      ovf_o       <= 1'b0;
    end else begin
      sop_pulse_o <= valid_i && sop_i;
      sop_err_o   <= valid_i && bad_word;
      ovf_o       <= valid_i && first && !space_i;
      if (valid_i) begin
        word_q    <= last ? '0 : word_q + WORD_W'(1);
        discard_q <= drop_now && !last;
        sop_bad_q <= bad_acc;
        err_q     <= err_acc;
        if (commit_o)
          slot_q <= (slot_q == SLOT_W'(NUM_CELLS - 1)) ? '0 : slot_q + SLOT_W'(1);
      end
    end
  end

  // R3
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(!space_i));
endmodule

// File: rtl/cf_rd_ctrl.sv
module cf_rd_ctrl #(
  parameter int CELL_WORDS = 13,
  parameter int NUM_CELLS  = 4,
  localparam int WORD_W = $clog2(CELL_WORDS),
  localparam int SLOT_W = $clog2(NUM_CELLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              avail_i,
  input  logic              flag_i,
  output logic              re_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [WORD_W-1:0] word_o,
  output logic              release_o,
  output logic              valid_o,
  output logic              sop_o,
  output logic              eop_o,
  output logic              err_o,
  output logic              udf_o
);
  import cf_pkg::*;

  logic [WORD_W-1:0] word_q;
  logic [SLOT_W-1:0] slot_q;
  logic     last;
  cf_mark_t mark_q;

  assign last      = word_q == WORD_W'(CELL_WORDS - 1);
  assign re_o      = strobe_i && avail_i;
  assign release_o = re_o && last;
  assign slot_o    = slot_q;
  assign word_o    = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      slot_q  <= '0;
      mark_q  <= '0;
      valid_o <= 1'b0;
      udf_o   <= 1'b0;
    end else begin
      valid_o <= re_o;
      udf_o   <= strobe_i && !avail_i;
      mark_q  <= '{sop: re_o && word_q == '0, eop: release_o, err: re_o && flag_i};
      if (re_o) begin
        word_q <= last ? '0 : word_q + WORD_W'(1);
        if (last)
          slot_q <= (slot_q == SLOT_W'(NUM_CELLS - 1)) ? '0 : slot_q + SLOT_W'(1);
      end
    end
  end

  assign sop_o = mark_q.sop;
  assign eop_o = mark_q.eop;
  assign err_o = mark_q.err;

  // R4
  udf_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_o |-> !valid_o);

  // R8
  eop_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eop_o || sop_o) |-> valid_o);
endmodule

// File: rtl/cell_fifo.sv
module cell_fifo #(
  parameter int DATA_W       = 32,
  parameter int CELL_WORDS   = 13,
  parameter int NUM_CELLS    = 4,
  parameter bit DROP_BAD_SOP = 1'b1,
  localparam int WORD_W = $clog2(CELL_WORDS),
  localparam int SLOT_W = $clog2(NUM_CELLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_sop_i,
  input  logic              wr_err_i,
  output logic              cell_space_o,
  output logic              sop_pulse_o,
  output logic              sop_err_o,
  output logic              ovf_err_o,
  input  logic              rd_strobe_i,
  output logic              cell_avail_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_sop_o,
  output logic              rd_eop_o,
  output logic              rd_err_o,
  output logic              udf_err_o
);
  logic              busy, mem_we, commit, commit_err, re, release_c, rflag;
  logic [SLOT_W-1:0] wslot, rslot;
  logic [WORD_W-1:0] wword, rword;
  logic [DATA_W-1:0] wdata;

  cf_wr_ctrl #(
    .DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .NUM_CELLS(NUM_CELLS),
    .DROP_BAD_SOP(DROP_BAD_SOP)
  ) u_wr (
    .clk_i, .rst_ni,
    .valid_i(wr_valid_i), .data_i(wr_data_i), .sop_i(wr_sop_i), .err_i(wr_err_i),
    .space_i(cell_space_o), .busy_o(busy), .mem_we_o(mem_we),
    .slot_o(wslot), .word_o(wword), .mem_data_o(wdata),
    .commit_o(commit), .commit_err_o(commit_err),
    .sop_pulse_o, .sop_err_o, .ovf_o(ovf_err_o)
  );

  cf_occ #(.NUM_CELLS(NUM_CELLS)) u_occ (
    .clk_i, .rst_ni, .commit_i(commit), .release_i(release_c), .busy_i(busy),
    .avail_o(cell_avail_o), .space_o(cell_space_o)
  );

  cf_store #(.DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .NUM_CELLS(NUM_CELLS)) u_store (
    .clk_i, .rst_ni,
    .we_i(mem_we), .wslot_i(wslot), .wword_i(wword), .wdata_i(wdata),
    .fwe_i(commit), .fval_i(commit_err),
    .re_i(re), .rslot_i(rslot), .rword_i(rword),
    .rdata_o(rd_data_o), .rflag_o(rflag)
  );

  cf_rd_ctrl #(.CELL_WORDS(CELL_WORDS), .NUM_CELLS(NUM_CELLS)) u_rd (
    .clk_i, .rst_ni,
    .strobe_i(rd_strobe_i), .avail_i(cell_avail_o), .flag_i(rflag),
    .re_o(re), .slot_o(rslot), .word_o(rword), .release_o(release_c),
    .valid_o(rd_valid_o), .sop_o(rd_sop_o), .eop_o(rd_eop_o), .err_o(rd_err_o),
    .udf_o(udf_err_o)
  );

  // R10
  rd_after_avail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(cell_avail_o));
endmodule

// File: tb/cell_fifo_tb.sv
module cell_fifo_tb_top;
  localparam int DW = 32;
  localparam int CW = 13;
  localparam int NC = 4;

  // [15] sop missing, [11:8] spurious sop word (0=none), [7:4] err word+1 (0=none),
  // [1] expect kept, [0] expect rd_err
  localparam logic [15:0] VEC [6] = '{16'h0002, 16'h0043, 16'h0500,
                                      16'h8000, 16'h00D3, 16'h0002};

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, wr_sop = 0, wr_err = 0, rd_strobe = 0;
  logic [DW-1:0] wr_data = '0;
  logic space, sop_p, sop_e, ovf, avail, rv, rs, re_, rerr, udf;
  logic [DW-1:0] rdata;
  int checks = 0, errors = 0;
  int n_sop_err, n_sop_p, n_ovf;
  bit done = 0;

  always #4 clk = ~clk;

  cell_fifo #(.DATA_W(DW), .CELL_WORDS(CW), .NUM_CELLS(NC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_sop_i(wr_sop), .wr_err_i(wr_err),
    .cell_space_o(space), .sop_pulse_o(sop_p), .sop_err_o(sop_e), .ovf_err_o(ovf),
    .rd_strobe_i(rd_strobe), .cell_avail_o(avail), .rd_valid_o(rv), .rd_data_o(rdata),
    .rd_sop_o(rs), .rd_eop_o(re_), .rd_err_o(rerr), .udf_err_o(udf)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // write words from..to of a cell; called at a falling edge
  task automatic wr_span(input logic [15:0] tag, input int from, input int to,
                         input bit miss, input int spur, input int errp);
    for (int w = from; w <= to; w++) begin
      wr_valid = 1;
      wr_data  = {tag, 16'(w)};
      wr_sop   = (w == 0) ? !miss : (spur != 0 && w == spur);
      wr_err   = (errp != 0 && w == errp - 1);
      @(negedge clk);
      n_sop_err += int'(sop_e);
      n_sop_p   += int'(sop_p);
      n_ovf     += int'(ovf);
    end
    wr_valid = 0; wr_sop = 0; wr_err = 0;
  endtask

  task automatic rd_cell(input logic [15:0] tag, input bit experr, input string req);
    for (int w = 0; w < CW; w++) begin
      rd_strobe = 1;
      @(negedge clk);
      chk(rv, {req, " R8 valid"}, rv, 1);
      chk(rdata == {tag, 16'(w)}, {req, " R1 data"}, rdata, {tag, 16'(w)});
      chk(rs == (w == 0), "R8 sop", rs, w == 0);
      chk(re_ == (w == CW - 1), "R8 eop", re_, w == CW - 1);
      chk(rerr == experr, "R9 err", rerr, experr);
      chk(!udf, "R4 no udf", udf, 0);
    end
    rd_strobe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(space, "R2 reset space", space, 1);
    chk(!avail, "R10 reset avail", avail, 0);
    chk(!rv && !udf && !ovf && !sop_e && !sop_p, "R4 reset outputs", {rv, udf, ovf, sop_e, sop_p}, 0);
    rst_n = 1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < 6; i++) begin
      logic [15:0] v;
      int spur;
      v = VEC[i];
      spur = int'(v[11:8]);
      n_sop_err = 0; n_sop_p = 0; n_ovf = 0;
      wr_span(16'h00A0 + 16'(i), 0, CW - 1, v[15], spur, int'(v[7:4]));
      chk(n_sop_err == int'(v[15]) + int'(spur != 0), "R6 sop_err count", n_sop_err,
          int'(v[15]) + int'(spur != 0));
      chk(n_sop_p == int'(!v[15]) + int'(spur != 0), "R5 sop pulse count", n_sop_p,
          int'(!v[15]) + int'(spur != 0));
      chk(n_ovf == 0, "R3 no ovf", n_ovf, 0);
      chk(avail == v[1], "R7 cell kept/dropped", avail, v[1]);
      if (v[1]) rd_cell(16'h00A0 + 16'(i), v[0], "vec");
      chk(!avail, "R10 empty after vec", avail, 0);
    end

    // fill to capacity, partial visibility
    n_sop_err = 0; n_sop_p = 0; n_ovf = 0;
    wr_span(16'h0100, 0, 5, 0, 0, 0);
    chk(!avail, "R10 partial cell hidden", avail, 0);
    chk(space, "R2 space with one in progress", space, 1);
    wr_span(16'h0100, 6, CW - 1, 0, 0, 0);
    chk(avail, "R10 avail after last word", avail, 1);
    for (int c = 1; c < NC; c++) begin
      chk(space, "R2 space before cell", space, 1);
      wr_span(16'h0100 + 16'(c), 0, 5, 0, 0, 0);
      if (c == NC - 1) chk(!space, "R2 no space full+in-progress", space, 0);
      wr_span(16'h0100 + 16'(c), 6, CW - 1, 0, 0, 0);
    end
    chk(!space, "R2 full no space", space, 0);
    chk(n_ovf == 0, "R1 fill no ovf", n_ovf, 0);

    // overflow cell
    n_ovf = 0;
    wr_span(16'h01FF, 0, CW - 1, 0, 0, 0);
    chk(n_ovf == 1, "R3 ovf pulse", n_ovf, 1);

    for (int c = 0; c < NC; c++) rd_cell(16'h0100 + 16'(c), 0, "drain");
    chk(!avail, "R3 dropped cell absent", avail, 0);
    chk(space, "R2 space after drain", space, 1);

    // underflow
    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0;
    chk(udf, "R4 udf pulse", udf, 1);
    chk(!rv, "R4 no valid on udf", rv, 0);
    @(negedge clk);
    chk(!udf, "R4 udf single pulse", udf, 0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule